// File: doc/BRIEF.md
# Incremental Servo Tracking Regulator

This block is the digital half of a bang-bang current regulator. A one-bit comparator reports whether the regulated current is above or below its target. On every step tick, while the regulator is enabled, the block nudges a DAC code by exactly one count in the direction that corrects the error. The DAC is driven in negative logic: code zero requests full drive and the all-ones code requests none. A higher code therefore means less current, so a low comparator level (current too high) makes the code count up.

When the enable is low, for example while the controlled output is switched off between pulses, the code is frozen. The next pulse then starts from the last regulated value. The code saturates at both ends instead of wrapping, so a slow-rising load at turn-on cannot push the count past zero into the all-ones code. The comparator is passed through a two-stage synchronizer. An internal divider makes the step tick from the clock, and that ratio sets the loop response. An output flag reports when the code rests at either limit.

Top module: `servo_track_reg`

## Requirements
- R1: A clock edge with `rst` high loads `dac_code` with `INIT_CODE` (default 512 for the default width), and `at_limit` then reads 0.
- R2: With `enable` high and the synchronized comparator at 0, `dac_code` rises by one on each step tick. With `DIV_RATIO` = 10, it rises by exactly 10 over any 100 consecutive clocks.
- R3: With `enable` high and the synchronized comparator at 1, `dac_code` falls by one on each step tick, which is 10 counts per 100 clocks at the default ratio.
- R4: While `enable` is low, `dac_code` holds its value whatever `cmp_in` does.
- R5: An up step at the all-ones code leaves the code at all ones (never 0), and `at_limit` reads 1 there.
- R6: A down step at code 0 leaves the code at 0 (never all ones), and `at_limit` reads 1 there.
- R7: The code changes by at most one count per clock, and two changes are at least `DIV_RATIO` clocks apart.
- R8: A step applied at clock edge k uses the `cmp_in` level sampled at edge k-2. A level set after edge k-2 only affects the following tick.
- R9: In closed loop with a plant whose drive is (all-ones minus code) and whose comparator reads 1 while drive is below target, the code settles to (all-ones minus target) or one above it. It then stays within a one-count band.
- R10: With `CODE_W` = 8 and `DIV_RATIO` = 1, the code steps on every clock and saturates at 255 and at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the initial code |
| enable | input | 1 | Regulator on; low freezes the code |
| cmp_in | input | 1 | Asynchronous comparator level; 1 = current below target |
| dac_code | output | CODE_W | Negative-logic DAC code |
| at_limit | output | 1 | High while the code is 0 or all ones |

## Verification
The loop is first opened and driven with a constant comparator level in each direction. This separates the step direction and step rate from the tick divider phase. A comparator change placed one clock before and one clock after the synchronizer capture window checks the two-edge latency exactly. A toggling comparator with the enable low shows that the hold really ignores the input. A table of closed-loop targets then covers mid-range equilibria, where the code must settle into a one-count limit cycle, and unreachable targets at both ends, where only saturation without wrap gives the expected code. A second, 8-bit instance with an undivided tick checks the width variant and the bypassed divider.

// File: rtl/servo_pkg.sv
package servo_pkg;

   // Action applied to the code register on a clock edge
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

endpackage

// File: rtl/servo_sync.sv
module servo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/servo_tick.sv
module servo_tick #(
   parameter int DIV_RATIO = 10
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   generate
      if (DIV_RATIO == 1) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_divide
         localparam int CNT_W = $clog2(DIV_RATIO);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)                cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/servo_sat_counter.sv
module servo_sat_counter
   import servo_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int INIT_CODE = 512
) (
   input  logic              clk,
   input  logic              rst,
   input  step_e             step,
   output logic [CODE_W-1:0] code,
   output logic              at_lo,
   output logic              at_hi
);

   localparam logic [CODE_W-1:0] CODE_MAX = '1;
   localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(INIT_CODE);

   always_ff @(posedge clk) begin
      if (rst) begin
         code <= CODE_INIT;
      end else begin
         case (step)
            STEP_UP:   if (code != CODE_MAX) code <= code + 1'b1;
            STEP_DOWN: if (code != '0)       code <= code - 1'b1;
            default:   ;
         endcase
      end
   end

   assign at_lo = (code == '0);
   assign at_hi = (code == CODE_MAX);

endmodule

// File: rtl/servo_track_reg.sv
module servo_track_reg
   import servo_pkg::*;
#(
   parameter int CODE_W      = 10,
   parameter int DIV_RATIO   = 10,
   parameter int INIT_CODE   = 1 << (CODE_W - 1),
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              cmp_in,
   output logic [CODE_W-1:0] dac_code,
   output logic              at_limit
);

   initial begin
      assert (CODE_W >= 4 && CODE_W <= 16)
         else $error("servo_track_reg: CODE_W out of range");
      assert (DIV_RATIO >= 1)
         else $error("servo_track_reg: DIV_RATIO must be at least 1");
      assert (INIT_CODE >= 0 && INIT_CODE < (1 << CODE_W))
         else $error("servo_track_reg: INIT_CODE does not fit CODE_W");
      assert (SYNC_STAGES >= 2)
         else $error("servo_track_reg: SYNC_STAGES must be at least 2");
   end

   logic  cmp_s;
   logic  tick;
   logic  lo_hit;
   logic  hi_hit;
   step_e step;

   servo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (cmp_in),
      .q_sync  (cmp_s)
   );

   servo_tick #(.DIV_RATIO(DIV_RATIO)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   // Comparator high means current is short: lower the code to raise drive
   always_comb begin
      step = STEP_HOLD;
      if (tick && enable) step = cmp_s ? STEP_DOWN : STEP_UP;
   end

   servo_sat_counter #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .code  (dac_code),
      .at_lo (lo_hit),
      .at_hi (hi_hit)
   );

   assign at_limit = lo_hit | hi_hit;

endmodule

// File: rtl/servo_track_reg_chk.sv
module servo_track_reg_chk #(
   parameter int CODE_W    = 10,
   parameter int DIV_RATIO = 10,
   parameter int INIT_CODE = 512
) (
   input logic              clk,
   input logic              rst,
   input logic              enable,
   input logic              cmp_in,
   input logic [CODE_W-1:0] dac_code,
   input logic              at_limit
);

   localparam logic [CODE_W-1:0] CODE_MAX = '1;

   logic [2:0]        since = 3'd0;
   logic [CODE_W-1:0] last_code;
   int                gap;
   logic              changed;

   always_ff @(posedge clk) begin
      last_code <= dac_code;
      if (rst)                since <= 3'd0;
      else if (since != 3'd7) since <= since + 3'd1;
      if (rst)                   gap <= DIV_RATIO;
      else if (changed)          gap <= 1;
      else if (gap < DIV_RATIO)  gap <= gap + 1;
   end

   assign changed = (dac_code != last_code);

   // R1
   rst_load_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dac_code == CODE_W'(INIT_CODE) && !at_limit));

   // R4
   hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd2 && !$past(rst) && !$past(enable)) |-> $stable(dac_code));

   // R5
   no_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd2 && !$past(rst) && $past(dac_code) == CODE_MAX) |-> dac_code != '0);

   // R6
   no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd2 && !$past(rst) && $past(dac_code) == '0) |-> dac_code != CODE_MAX);

   // R7
   unit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd2 && !$past(rst)) |->
         (int'(dac_code) - int'($past(dac_code)) <= 1 &&
          int'($past(dac_code)) - int'(dac_code) <= 1));

   // R7
   step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd2 && changed) |-> gap >= DIV_RATIO);

   // R8
   up_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd4 && !$past(rst) && dac_code > $past(dac_code)) |-> !$past(cmp_in, 3));

   // R8
   down_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 3'd4 && !$past(rst) && dac_code < $past(dac_code)) |-> $past(cmp_in, 3));

endmodule

bind servo_track_reg servo_track_reg_chk #(
   .CODE_W    (CODE_W),
   .DIV_RATIO (DIV_RATIO),
   .INIT_CODE (INIT_CODE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .enable   (enable),
   .cmp_in   (cmp_in),
   .dac_code (dac_code),
   .at_limit (at_limit)
);

// File: tb/servo_track_reg_tb_top.sv
module servo_track_reg_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 10;
   localparam int CMAX       = (1 << CW) - 1;
   localparam int NV         = 5;
   // closed-loop table: target drive, expected code, tolerance, expected limit flag
   localparam int TGT [NV] = '{300, 700, 0, 2000, 512};
   localparam int EXPC[NV] = '{723, 323, 1023, 0, 511};
   localparam int TOL [NV] = '{2, 2, 0, 0, 2};
   localparam int LIM [NV] = '{0, 0, 1, 1, 0};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          enable = 1'b0;
   logic          cmp_man = 1'b0;
   logic          plant_on = 1'b0;
   int            target = 0;
   logic          cmp_in;
   logic [CW-1:0] dac_code;
   logic          at_limit;

   logic          en8 = 1'b0;
   logic          cmp8 = 1'b0;
   logic [7:0]    code8;
   logic          lim8;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // plant: drive falls as code rises; comparator high when drive is short
   assign cmp_in = plant_on ? ((CMAX - int'(dac_code)) < target) : cmp_man;

   servo_track_reg dut_i (
      .clk      (clk),
      .rst      (rst),
      .enable   (enable),
      .cmp_in   (cmp_in),
      .dac_code (dac_code),
      .at_limit (at_limit)
   );

   servo_track_reg #(.CODE_W(8), .DIV_RATIO(1)) dut8_i (
      .clk      (clk),
      .rst      (rst),
      .enable   (en8),
      .cmp_in   (cmp8),
      .dac_code (code8),
      .at_limit (lim8)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int c0;
      int lo;
      int hi;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      check(int'(dac_code) == 512, "R1 init code", int'(dac_code), 512);
      check(at_limit == 1'b0, "R1 limit flag", int'(at_limit), 0);

      // R2 up steps at one per tick
      enable = 1'b1;
      cmp_man = 1'b0;
      cyc(5);
      c0 = int'(dac_code);
      cyc(100);
      check(int'(dac_code) == c0 + 10, "R2 up rate", int'(dac_code), c0 + 10);

      // R3 down steps
      cmp_man = 1'b1;
      cyc(5);
      c0 = int'(dac_code);
      cyc(100);
      check(int'(dac_code) == c0 - 10, "R3 down rate", int'(dac_code), c0 - 10);

      // R4 hold while disabled, comparator toggling
      enable = 1'b0;
      cyc(3);
      c0 = int'(dac_code);
      for (int i = 0; i < 60; i++) begin
         cmp_man = ~cmp_man;
         cyc(1);
      end
      check(int'(dac_code) == c0, "R4 hold", int'(dac_code), c0);

      // R8 synchronizer latency: locate a tick edge, then change the level late
      cmp_man = 1'b1;
      enable = 1'b1;
      cyc(3);
      c0 = int'(dac_code);
      while (int'(dac_code) == c0) cyc(1);
      c0 = int'(dac_code);
      cyc(8);
      cmp_man = 1'b0;
      cyc(2);
      check(int'(dac_code) == c0 - 1, "R8 late level ignored", int'(dac_code), c0 - 1);
      cyc(10);
      check(int'(dac_code) == c0, "R8 level used next tick", int'(dac_code), c0);

      // R1 reset in mid operation
      rst = 1'b1;
      cyc(1);
      rst = 1'b0;
      check(int'(dac_code) == 512, "R1 reload", int'(dac_code), 512);

      // R9 R5 R6 closed loop table
      plant_on = 1'b1;
      for (int v = 0; v < NV; v++) begin
         target = TGT[v];
         cyc(11000);
         check(int'(dac_code) >= EXPC[v] - TOL[v] && int'(dac_code) <= EXPC[v] + TOL[v],
               (LIM[v] != 0) ? "R5/R6 saturated code" : "R9 settled code",
               int'(dac_code), EXPC[v]);
         check(int'(at_limit) == LIM[v], "R5/R6/R9 limit flag", int'(at_limit), LIM[v]);
         if (LIM[v] == 0) begin
            lo = int'(dac_code);
            hi = int'(dac_code);
            for (int i = 0; i < 200; i++) begin
               cyc(1);
               if (int'(dac_code) < lo) lo = int'(dac_code);
               if (int'(dac_code) > hi) hi = int'(dac_code);
            end
            check(hi - lo <= 1, "R9 limit cycle band", hi - lo, 1);
         end
      end
      plant_on = 1'b0;

      // R10 8-bit variant with undivided tick
      check(int'(code8) == 128, "R10 init", int'(code8), 128);
      en8 = 1'b1;
      cmp8 = 1'b0;
      cyc(4);
      c0 = int'(code8);
      cyc(20);
      check(int'(code8) == c0 + 20, "R10 step every clock", int'(code8), c0 + 20);
      cyc(300);
      check(int'(code8) == 255 && lim8, "R10 top saturation", int'(code8), 255);
      cmp8 = 1'b1;
      cyc(300);
      check(int'(code8) == 0 && lim8, "R10 bottom saturation", int'(code8), 0);

      finish_run();
   end

endmodule